// File: doc/BRIEF.md
# NOR Flash Command Sequence Interpreter

This block sits on the device side of a parallel NOR flash bus and follows the host's write strobes. A small sequencer matches multi-write unlock patterns and starts one of two embedded operations on a small word-array model. The first is chip erase, which zeroes every word, checks the zeroes and then sets every word to FFFFh. The second is word program, which can only clear bits and which the host may suspend and resume. While an operation runs, reads return a status word with toggling bits instead of array data.

The host uses it like a flash part, with plain write and read strobes on a synchronous clock. Data is 16 bits wide. Command matching uses the low byte of the write data and twelve bits of word address. All embedded operation lengths and the suspend latency are parameters counted in clock cycles.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: Chip erase starts only after these six writes, in this order (word address/low data byte): 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h. Any write with a wrong address or value returns the sequencer to idle without starting anything.
- R2: `busy` rises in the cycle after the sixth erase write and stays high for exactly 2*DEPTH+ERASE_CYC cycles: DEPTH cycles of zeroing, DEPTH cycles of zero checking and ERASE_CYC cycles of erase. Afterwards every word reads FFFFh.
- R3: Every write made while an erase runs, including suspend and complete program sequences, is ignored. The erase time and the array contents are unchanged by it.
- R4: A read while busy returns a status word. For erase, bit 7 is 0 and bits 6 and 2 both invert on each busy read. For program, bit 7 is the inverse of bit 7 of the data being programmed, bit 6 inverts on each busy read, and bit 2 is 0. All other bits are 0.
- R5: Driving `rst_n` low ends a running erase at once and `busy` falls with no clock edge. Words already zeroed stay zero, and only a complete new six-write sequence erases the array.
- R6: Program is 555h/AAh, 2AAh/55h, 555h/A0h, then a write of the word address and data. `busy` is high for PROG_CYC cycles, and afterwards the word holds its old value AND the new data.
- R7: Data B0h written at any address during a program keeps `busy` high for SUSP_CYC more cycles and then drops it. While suspended, a read outside the suspended sector (SECT_WORDS aligned words) returns array data. A read inside that sector returns the status word.
- R8: Data 30h written at any address while suspended resumes the program for exactly the cycles that remained, and the program then completes normally.
- R9: In read mode, `rdata` shows the word at the address presented with `rd_en`, one cycle later. After reset, `busy` is 0 and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | AW | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read result: array word or status word |
| busy | output | 1 | An embedded operation is running |

## Verification
The hardest state to reach is a reset that lands after the zeroing pass but before the final erase. Only that case shows at the ports that the array was actually preprogrammed. The bench counts cycles from the sixth write into the check pass, pulses reset, and then reads a word that had been programmed earlier, which must now be 0000h. Suspend is reached in a similar way: a program is started, a status read and idle cycles are placed before B0h so that the remaining count is known, and the measured busy length after resume is compared with it.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {SQ_IDLE, SQ_U1, SQ_U2, SQ_SETUP, SQ_E1, SQ_E2, SQ_PGM} seq_t;
  typedef enum logic [2:0] {EN_IDLE, EN_PROG, EN_SWAIT, EN_SUSP, EN_PRE, EN_VER, EN_ERASE} eng_t;

  localparam logic [11:0] ADR_A = 12'h555;
  localparam logic [11:0] ADR_B = 12'h2AA;
  localparam logic [7:0]  KEY_A = 8'hAA;
  localparam logic [7:0]  KEY_B = 8'h55;
  localparam logic [7:0]  OP_SETUP = 8'h80;
  localparam logic [7:0]  OP_CHIP  = 8'h10;
  localparam logic [7:0]  OP_PGM   = 8'hA0;
  localparam logic [7:0]  OP_SUSP  = 8'hB0;
  localparam logic [7:0]  OP_RES   = 8'h30;

  // NOR cells can only be cleared by programming
  function automatic logic [15:0] nor_merge(input logic [15:0] old_w, input logic [15:0] new_w);
    return old_w & new_w;
  endfunction

  function automatic logic [15:0] status_word(input logic is_erase, input logic tg, input logic d7);
    logic [15:0] w;
    w    = '0;
    w[7] = is_erase ? 1'b0 : ~d7;
    w[6] = tg;
    w[2] = is_erase ? tg : 1'b0;
    return w;
  endfunction
endpackage

// File: rtl/cmd_seq.sv
module cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wbyte,
  input  logic          accept,
  output logic          cmd_prog,
  output logic          cmd_erase
);
  seq_t st, nxt;
  logic hit_a, hit_b;

  assign hit_a = (addr[11:0] == ADR_A);
  assign hit_b = (addr[11:0] == ADR_B);

  always_comb begin
    nxt       = st;
    cmd_prog  = 1'b0;
    cmd_erase = 1'b0;
    if (!accept) nxt = SQ_IDLE;
    else if (wr_en) begin
      case (st)
        SQ_IDLE:  nxt = (hit_a && wbyte == KEY_A) ? SQ_U1 : SQ_IDLE;
        SQ_U1:    nxt = (hit_b && wbyte == KEY_B) ? SQ_U2 : SQ_IDLE;
        SQ_U2:    nxt = (hit_a && wbyte == OP_SETUP) ? SQ_SETUP :
                        (hit_a && wbyte == OP_PGM)   ? SQ_PGM   : SQ_IDLE;
        SQ_SETUP: nxt = (hit_a && wbyte == KEY_A) ? SQ_E1 : SQ_IDLE;
        SQ_E1:    nxt = (hit_b && wbyte == KEY_B) ? SQ_E2 : SQ_IDLE;
        SQ_E2: begin
          cmd_erase = hit_a && wbyte == OP_CHIP;
          nxt       = SQ_IDLE;
        end
        SQ_PGM: begin
          cmd_prog = 1'b1;
          nxt      = SQ_IDLE;
        end
        default: nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= SQ_IDLE;
    else        st <= nxt;

  // R1: the last erase key is only taken after the fifth correct write
  assert_erase_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_erase |-> (st == SQ_E2));
endmodule

// File: rtl/erase_engine.sv
module erase_engine
  import flash_cmd_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int PROG_CYC  = 20,
  parameter int SUSP_CYC  = 10,
  parameter int ERASE_CYC = 30,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(PROG_CYC + SUSP_CYC + ERASE_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [15:0]   wdata,
  input  logic [IW-1:0] widx,
  input  logic          cmd_prog,
  input  logic          cmd_erase,
  input  logic [15:0]   chk_word,
  output eng_t          st,
  output logic          busy,
  output logic          accept,
  output logic          op_erase,
  output logic [IW-1:0] p_idx,
  output logic [15:0]   p_data,
  output logic          commit,
  output logic          zero_we,
  output logic [IW-1:0] walk_idx,
  output logic          set_ones
);
  logic [CW-1:0] cnt, psave;
  logic          last_word, cnt_done;

  assign last_word = (walk_idx == IW'(DEPTH - 1));
  assign cnt_done  = (cnt == '0);
  assign accept    = (st == EN_IDLE);
  assign busy      = (st != EN_IDLE) && (st != EN_SUSP);
  assign commit    = (st == EN_PROG) && cnt_done;
  assign zero_we   = (st == EN_PRE);
  assign set_ones  = (st == EN_ERASE) && cnt_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= EN_IDLE;
      cnt      <= '0;
      psave    <= '0;
      walk_idx <= '0;
      op_erase <= 1'b0;
      p_idx    <= '0;
      p_data   <= '0;
    end else begin
      case (st)
        EN_IDLE:
          if (cmd_erase) begin
            st       <= EN_PRE;
            walk_idx <= '0;
            op_erase <= 1'b1;
          end else if (cmd_prog) begin
            st       <= EN_PROG;
            cnt      <= CW'(PROG_CYC - 1);
            p_idx    <= widx;
            p_data   <= wdata;
            op_erase <= 1'b0;
          end
        EN_PROG:
          if (cnt_done) st <= EN_IDLE;
          else if (wr_en && wdata[7:0] == OP_SUSP) begin
            st    <= EN_SWAIT;
            psave <= cnt - 1'b1;
            cnt   <= CW'(SUSP_CYC - 1);
          end else cnt <= cnt - 1'b1;
        EN_SWAIT:
          if (cnt_done) st <= EN_SUSP;
          else          cnt <= cnt - 1'b1;
        EN_SUSP:
          if (wr_en && wdata[7:0] == OP_RES) begin
            st  <= EN_PROG;
            cnt <= psave;
          end
        EN_PRE:
          if (last_word) begin
            st       <= EN_VER;
            walk_idx <= '0;
          end else walk_idx <= walk_idx + 1'b1;
        EN_VER:
          if (last_word) begin
            st  <= EN_ERASE;
            cnt <= CW'(ERASE_CYC - 1);
          end else walk_idx <= walk_idx + 1'b1;
        EN_ERASE:
          if (cnt_done) st <= EN_IDLE;
          else          cnt <= cnt - 1'b1;
        default: st <= EN_IDLE;
      endcase
    end
  end

  assert_verify_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EN_VER) |-> (chk_word == 16'h0000));
  assert_no_cmd_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != EN_IDLE) |-> !(cmd_prog || cmd_erase));
  assert_susp_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EN_SUSP) |-> ($past(st) == EN_SUSP || $past(st) == EN_SWAIT));
endmodule

// File: rtl/word_store.sv
module word_store
  import flash_cmd_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we,
  input  logic [IW-1:0] prog_idx,
  input  logic [15:0]   prog_data,
  input  logic          zero_we,
  input  logic          set_ones,
  input  logic [IW-1:0] walk_idx,
  input  logic [IW-1:0] rd_idx,
  output logic [15:0]   rd_word,
  output logic [15:0]   chk_word
);
  logic [15:0] mem [DEPTH];

  assign rd_word  = mem[rd_idx];
  assign chk_word = mem[walk_idx];

  // storage keeps its contents across hardware reset
  always_ff @(posedge clk) begin
    if (set_ones) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
    end else begin
      if (zero_we) mem[walk_idx] <= 16'h0000;
      if (prog_we) mem[prog_idx] <= nor_merge(mem[prog_idx], prog_data);
    end
  end

  assert_prog_and_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |=> (mem[$past(prog_idx)] == ($past(mem[prog_idx]) & $past(prog_data))));
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW         = 12,
  parameter int DEPTH      = 16,
  parameter int SECT_WORDS = 4,
  parameter int PROG_CYC   = 20,
  parameter int SUSP_CYC   = 10,
  parameter int ERASE_CYC  = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  output logic          busy
);
  localparam int IW = $clog2(DEPTH);
  localparam int SB = $clog2(SECT_WORDS);

  eng_t          st;
  logic          accept, cmd_prog, cmd_erase, op_erase, commit, zero_we, set_ones;
  logic [IW-1:0] p_idx, walk_idx;
  logic [15:0]   p_data, rd_word, chk_word;
  logic          tgl, sect_hit, show_status;

  cmd_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wbyte(wdata[7:0]),
    .accept(accept), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase));

  erase_engine #(.DEPTH(DEPTH), .PROG_CYC(PROG_CYC), .SUSP_CYC(SUSP_CYC),
                 .ERASE_CYC(ERASE_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .widx(addr[IW-1:0]),
    .cmd_prog(cmd_prog), .cmd_erase(cmd_erase), .chk_word(chk_word), .st(st),
    .busy(busy), .accept(accept), .op_erase(op_erase), .p_idx(p_idx),
    .p_data(p_data), .commit(commit), .zero_we(zero_we), .walk_idx(walk_idx),
    .set_ones(set_ones));

  word_store #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .prog_we(commit), .prog_idx(p_idx), .prog_data(p_data),
    .zero_we(zero_we), .set_ones(set_ones), .walk_idx(walk_idx),
    .rd_idx(addr[IW-1:0]), .rd_word(rd_word), .chk_word(chk_word));

  assign sect_hit    = (addr[IW-1:SB] == p_idx[IW-1:SB]);
  assign show_status = busy || (st == EN_SUSP && sect_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      tgl   <= 1'b0;
    end else if (rd_en) begin
      rdata <= show_status ? status_word(op_erase, tgl, p_data[7]) : rd_word;
      if (busy) tgl <= ~tgl;
    end
  end

  assert_erase_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && op_erase) |=> (rdata[7] == 1'b0 && rdata[6] == rdata[2]));
endmodule

// File: tb/sim_nor_cmd_ctrl.sv
module sim_nor_cmd_ctrl;
  localparam int DEPTH = 16, PROG = 20, SUSP = 10, ERASE = 30;
  localparam int ERASE_LEN = 2 * DEPTH + ERASE;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic busy;
  int errors = 0, checks = 0, cyc = 0;

  always #4 clk = ~clk;

  nor_cmd_ctrl #(.AW(12), .DEPTH(DEPTH), .SECT_WORDS(4), .PROG_CYC(PROG),
                 .SUSP_CYC(SUSP), .ERASE_CYC(ERASE)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy));

  // program entries: address, data, expected word afterwards
  localparam logic [43:0] VEC [5] = '{
    {12'h001, 16'h1234, 16'h1234},
    {12'h002, 16'hABCD, 16'hABCD},
    {12'h001, 16'hF0F0, 16'h1030},
    {12'h00F, 16'h0000, 16'h0000},
    {12'h005, 16'h8001, 16'h8001}};

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    d = rdata; rd_en = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic erase_seq(input logic [7:0] k5, input logic [11:0] a6);
    wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h555, 16'h80);
    wr(12'h555, 16'hAA); wr(12'h2AA, {8'h0, k5}); wr(a6, 16'h10);
  endtask

  task automatic prog_seq(input logic [11:0] a, input logic [15:0] d);
    wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h555, 16'hA0); wr(a, d);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] r1, r2;
    int n;
    logic ok;
    repeat (3) @(negedge clk);
    chk("R9 reset busy", {15'h0, busy}, 16'h0);
    chk("R9 reset rdata", rdata, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: wrong fifth key, then wrong final address
    erase_seq(8'h56, 12'h555);
    @(negedge clk);
    chk("R1 bad key no start", {15'h0, busy}, 16'h0);
    erase_seq(8'h55, 12'h556);
    @(negedge clk);
    chk("R1 bad address no start", {15'h0, busy}, 16'h0);

    // R2: exact erase length, then all ones
    erase_seq(8'h55, 12'h555);
    count_busy(n);
    chk("R2 erase length", 16'(n), 16'(ERASE_LEN));
    ok = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      rd(12'(i), r1);
      if (r1 !== 16'hFFFF) ok = 1'b0;
    end
    chk("R2 all words erased", {15'h0, ok}, 16'h1);

    // R6 R9: table of program operations
    for (int i = 0; i < 5; i++) begin
      prog_seq(VEC[i][43:32], VEC[i][31:16]);
      count_busy(n);
      chk("R6 program length", 16'(n), 16'(PROG));
      rd(VEC[i][43:32], r1);
      chk("R6 R9 program result", r1, VEC[i][15:0]);
    end

    // R4 R3: status reads and stray writes during erase
    erase_seq(8'h55, 12'h555);
    rd(12'h001, r1);
    rd(12'h001, r2);
    chk("R4 erase status toggles", r1 ^ r2, 16'h0044);
    chk("R4 erase status fixed bits", r1 & 16'hFFBB, 16'h0000);
    prog_seq(12'h001, 16'h0000);
    wr(12'h000, 16'hB0);
    count_busy(n);
    chk("R3 erase length unchanged", 16'(n), 16'(ERASE_LEN - 7));
    rd(12'h001, r1);
    chk("R3 stray program ignored", r1, 16'hFFFF);

    // R5: reset during the zero-check pass
    prog_seq(12'h003, 16'h5A5A);
    count_busy(n);
    erase_seq(8'h55, 12'h555);
    repeat (DEPTH + 4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R5 busy drops on reset", {15'h0, busy}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'h003, r1);
    chk("R5 preprogrammed zero left", r1, 16'h0000);
    erase_seq(8'h55, 12'h555);
    count_busy(n);
    rd(12'h003, r1);
    chk("R5 repeated sequence erases", r1, 16'hFFFF);

    // R7 R8: suspend and resume of a program
    prog_seq(12'h005, 16'h0055);
    rd(12'h005, r1);
    chk("R4 program status", r1 & 16'hFF84, 16'h0080);
    repeat (4) @(negedge clk);
    wr(12'h123, 16'hB0);
    count_busy(n);
    chk("R7 suspend latency", 16'(n), 16'(SUSP));
    rd(12'h009, r1);
    chk("R7 other sector readable", r1, 16'hFFFF);
    rd(12'h005, r1);
    chk("R7 suspended sector shows status", r1 & 16'hFF84, 16'h0080);
    wr(12'h0AB, 16'h30);
    count_busy(n);
    chk("R8 resume remaining cycles", 16'(n), 16'(PROG - 6));
    rd(12'h005, r1);
    chk("R8 program completes", r1, 16'h0055);

    finish_run();
  end
endmodule